// File: doc/BRIEF.md
# DDR SDRAM Command Bus Rule Monitor

This block sits beside the command pins of a four-bank double-data-rate SDRAM and samples them on every rising clock edge. It turns each pin pattern into a command code and keeps, for every bank, whether a row is open. It also keeps a set of down-counters that measure the spacing between commands in clock cycles. When a command breaks a bank-state rule or a spacing rule, a violation flag rises together with a code naming the broken rule. The flag stays set and keeps its first code until a clear input is pulsed.

All spacing limits are parameters in clock cycles. Their defaults match a 7.5 ns clock: activate to read/write 3, row cycle 9, row active 6, precharge 3, activate to activate across banks 2, and mode-register recovery 2. The burst length in force is given on a two-bit input. It is used to time the end of a burst for auto-precharge.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With the clock enabled in the previous and current cycles and chip select low, the pattern {ras_n,cas_n,we_n} is decoded as follows: 000 is mode set (code 1 when ba[0]=0, extended code 2 when ba[0]=1); 001 is auto refresh (code 3); 011 is activate (5); 101 is read (6); 100 is write (7); 110 is burst stop (8); 010 is precharge (9 when a10=0, all-bank 10 when a10=1). The pattern 111, and chip select high, give NOP (0). The code appears on last_cmd one cycle after the sampling edge.
- R2: ba selects the bank, and bank i is bit i of bank_open. An activate sets that bit, visible one cycle after the edge.
- R3: A precharge with a10=0 closes only the addressed bank. With a10=1 it closes every bank whatever ba holds.
- R4: A read or write with a10=1 closes its bank. That bank may be activated again only once burst cycles + TRP cycles have passed since the command; an earlier activate gives code 8.
- R5: Mode set, extended mode set, auto refresh or self-refresh entry while any bank is open gives code 2.
- R6: Any command other than NOP issued fewer than TMRD cycles after a mode set or extended mode set gives code 1.
- R7: A read or write fewer than TRCD cycles after its bank's activate gives code 6.
- R8: A precharge of an open bank fewer than TRAS cycles after its activate gives code 7. For the all-bank form, this applies to any open bank.
- R9: An activate fewer than TRP cycles after its bank closed gives code 8. An activate fewer than TRC cycles after the bank's previous activate gives code 9.
- R10: An activate fewer than TRRD cycles after an activate to any bank gives code 10.
- R11: An activate to an open bank gives code 3. A read or write to an idle bank gives code 4.
- R12: After a write with a10=1, a read or write issued before the burst ends gives code 5. bl_sel selects burst length: 2'b11 is 8 beats (4 cycles), 2'b10 is 4 beats (2 cycles), and any other value is 2 beats (1 cycle).
- R13: Reset clears the flag, the code, last_cmd and all banks. The first violation sets viol_flag and viol_code one cycle after its edge, and both then hold until clr_flag. clr_flag wins over a new violation in the same cycle. When one command breaks several rules, the code is the smallest of codes 1 to 10 that applies.
- R14: Refresh pattern 001 with cke falling is self-refresh entry (code 4). While the previous-cycle cke was low, every pattern is ignored, reported as code 11, and changes no bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_flag | input | 1 | Clears the sticky violation flag and code |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Address bit 10: auto-precharge / all-bank select |
| bl_sel | input | 2 | Burst length select |
| last_cmd | output | 4 | Code of the command sampled at the previous edge |
| bank_open | output | 4 | One bit per bank, set while a row is open |
| viol_flag | output | 1 | Sticky violation flag |
| viol_code | output | 4 | Code of the first violation, zero when none |

## Verification
The assertions check on every cycle that the flag stays sticky and holds its code steady, and that the code reads zero while the flag is low. They also check that an activate opens its bank, that a closing bank blocks re-activation for at least a cycle, and that self-refresh entry makes the next command read as ignored. Only the bench scenarios can show that each spacing rule trips at exactly its cycle count and not one cycle later. The same goes for the choice between codes when several rules break at once, for how the burst length stretches the auto-precharge window, and for how all-bank and single-bank precharge differ in what they close.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;
  typedef enum logic [3:0] {
    C_NOP  = 4'd0,
    C_MRS  = 4'd1,
    C_EMRS = 4'd2,
    C_AREF = 4'd3,
    C_SREF = 4'd4,
    C_ACT  = 4'd5,
    C_RD   = 4'd6,
    C_WR   = 4'd7,
    C_BST  = 4'd8,
    C_PRE  = 4'd9,
    C_PREA = 4'd10,
    C_IGN  = 4'd11
  } cmd_e;

  typedef enum logic [3:0] {
    V_NONE   = 4'd0,
    V_MRD    = 4'd1,
    V_BUSY   = 4'd2,
    V_REOPEN = 4'd3,
    V_CLOSED = 4'd4,
    V_WAPB   = 4'd5,
    V_RCD    = 4'd6,
    V_RAS    = 4'd7,
    V_RP     = 4'd8,
    V_RC     = 4'd9,
    V_RRD    = 4'd10
  } viol_e;
endpackage

// File: rtl/ddrmon_decode.sv
module ddrmon_decode
  import ddrmon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ba0,
  input  logic a10,
  output cmd_e cmd
);
  logic cke_q;

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b1;
    else     cke_q <= cke;
  end

  always_comb begin
    cmd = C_NOP;
    if (!cke_q) begin
      cmd = C_IGN;
    end else if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = ba0 ? C_EMRS : C_MRS;
        3'b001:  cmd = cke ? C_AREF : C_SREF;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b110:  cmd = C_BST;
        3'b010:  cmd = a10 ? C_PREA : C_PRE;
        default: cmd = C_NOP;
      endcase
    end
  end

  // R14: entering self refresh disables decoding on the next cycle
  p_sref_blocks_r14: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_SREF) |=> (cmd == C_IGN));
endmodule

// File: rtl/ddrmon_gap.sv
module ddrmon_gap #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          ok
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign ok = (cnt == '0);
endmodule

// File: rtl/ddrmon_bank.sv
module ddrmon_bank
  import ddrmon_pkg::*;
#(
  parameter int CW   = 4,
  parameter int TRCD = 3,
  parameter int TRAS = 6,
  parameter int TRC  = 9,
  parameter int TRP  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  cmd_e          cmd,
  input  logic          sel,
  input  logic          a10,
  input  logic [CW-1:0] bcyc,
  output logic          is_open,
  output logic          rcd_ok,
  output logic          ras_ok,
  output logic          rc_ok,
  output logic          rp_ok
);
  logic act, ap_close, pre_close, close;
  logic [CW-1:0] rp_val;

  assign act       = (cmd == C_ACT) && sel;
  assign ap_close  = ((cmd == C_RD) || (cmd == C_WR)) && sel && a10 && is_open;
  assign pre_close = is_open && (((cmd == C_PRE) && sel) || (cmd == C_PREA));
  assign close     = ap_close || pre_close;
  assign rp_val    = ap_close ? (CW'(TRP - 1) + bcyc) : CW'(TRP - 1);

  always_ff @(posedge clk) begin
    if (rst)        is_open <= 1'b0;
    else if (act)   is_open <= 1'b1;
    else if (close) is_open <= 1'b0;
  end

  ddrmon_gap #(.CW(CW)) u_rcd (.clk(clk), .rst(rst), .load(act),   .val(CW'(TRCD - 1)), .ok(rcd_ok));
  ddrmon_gap #(.CW(CW)) u_ras (.clk(clk), .rst(rst), .load(act),   .val(CW'(TRAS - 1)), .ok(ras_ok));
  ddrmon_gap #(.CW(CW)) u_rc  (.clk(clk), .rst(rst), .load(act),   .val(CW'(TRC - 1)),  .ok(rc_ok));
  ddrmon_gap #(.CW(CW)) u_rp  (.clk(clk), .rst(rst), .load(close), .val(rp_val),        .ok(rp_ok));

  // R2: an activate leaves the bank open
  p_act_opens_r2: assert property (@(posedge clk) disable iff (rst)
    act |=> is_open);

  // R9: a bank that has just closed cannot yet be reactivated
  p_close_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    ((TRP > 1) && $fell(is_open)) |-> !rp_ok);
endmodule

// File: rtl/ddrmon_flag.sv
module ddrmon_flag
  import ddrmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  viol_e      hit,
  output logic       flag,
  output logic [3:0] code
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flag <= 1'b0;
      code <= 4'd0;
    end else if (!flag && (hit != V_NONE)) begin
      flag <= 1'b1;
      code <= hit;
    end
  end

  p_sticky_r13: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> (flag && $stable(code)));

  p_code_zero_r13: assert property (@(posedge clk) disable iff (rst)
    !flag |-> (code == 4'd0));
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddrmon_pkg::*;
#(
  parameter int BAW  = 2,
  parameter int TRCD = 3,
  parameter int TRC  = 9,
  parameter int TRAS = 6,
  parameter int TRP  = 3,
  parameter int TRRD = 2,
  parameter int TMRD = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_flag,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] ba,
  input  logic       a10,
  input  logic [1:0] bl_sel,
  output logic [3:0] last_cmd,
  output logic [3:0] bank_open,
  output logic       viol_flag,
  output logic [3:0] viol_code
);
  localparam int NB  = 1 << BAW;
  localparam int G1  = (TRC > TRAS) ? TRC : TRAS;
  localparam int G2  = ((TRP + 4) > G1) ? (TRP + 4) : G1;
  localparam int G3  = (TRCD > G2) ? TRCD : G2;
  localparam int G4  = (TRRD > G3) ? TRRD : G3;
  localparam int G5  = (TMRD > G4) ? TMRD : G4;
  localparam int CW  = $clog2(G5 + 1);

  cmd_e          cmd;
  viol_e         hit;
  logic [CW-1:0] bcyc;
  logic [NB-1:0] open_v, rcd_ok, ras_ok, rc_ok, rp_ok;
  logic          rrd_ok, mrd_ok, wap_ok;
  logic          is_rw, quiet, is_mode, needs_idle;

  ddrmon_decode u_dec (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba0(ba[0]), .a10(a10), .cmd(cmd)
  );

  always_comb begin
    case (bl_sel)
      2'b11:   bcyc = CW'(4);
      2'b10:   bcyc = CW'(2);
      default: bcyc = CW'(1);
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_bank
      ddrmon_bank #(.CW(CW), .TRCD(TRCD), .TRAS(TRAS), .TRC(TRC), .TRP(TRP)) u_bank (
        .clk(clk), .rst(rst), .cmd(cmd), .sel(ba == BAW'(gi)), .a10(a10),
        .bcyc(bcyc), .is_open(open_v[gi]), .rcd_ok(rcd_ok[gi]),
        .ras_ok(ras_ok[gi]), .rc_ok(rc_ok[gi]), .rp_ok(rp_ok[gi])
      );
    end
  endgenerate

  assign is_rw      = (cmd == C_RD) || (cmd == C_WR);
  assign quiet      = (cmd == C_NOP) || (cmd == C_IGN);
  assign is_mode    = (cmd == C_MRS) || (cmd == C_EMRS);
  assign needs_idle = is_mode || (cmd == C_AREF) || (cmd == C_SREF);

  ddrmon_gap #(.CW(CW)) u_rrd (.clk(clk), .rst(rst), .load(cmd == C_ACT),
    .val(CW'(TRRD - 1)), .ok(rrd_ok));
  ddrmon_gap #(.CW(CW)) u_mrd (.clk(clk), .rst(rst), .load(is_mode),
    .val(CW'(TMRD - 1)), .ok(mrd_ok));
  ddrmon_gap #(.CW(CW)) u_wap (.clk(clk), .rst(rst), .load((cmd == C_WR) && a10),
    .val(bcyc - 1'b1), .ok(wap_ok));

  always_comb begin
    hit = V_NONE;
    if (!quiet && !mrd_ok)                                  hit = V_MRD;
    else if (needs_idle && (|open_v))                       hit = V_BUSY;
    else if ((cmd == C_ACT) && open_v[ba])                  hit = V_REOPEN;
    else if (is_rw && !open_v[ba])                          hit = V_CLOSED;
    else if (is_rw && !wap_ok)                              hit = V_WAPB;
    else if (is_rw && !rcd_ok[ba])                          hit = V_RCD;
    else if (((cmd == C_PRE) && open_v[ba] && !ras_ok[ba]) ||
             ((cmd == C_PREA) && (|(open_v & ~ras_ok))))    hit = V_RAS;
    else if ((cmd == C_ACT) && !rp_ok[ba])                  hit = V_RP;
    else if ((cmd == C_ACT) && !rc_ok[ba])                  hit = V_RC;
    else if ((cmd == C_ACT) && !rrd_ok)                     hit = V_RRD;
  end

  ddrmon_flag u_flag (
    .clk(clk), .rst(rst), .clr(clr_flag), .hit(hit),
    .flag(viol_flag), .code(viol_code)
  );

  always_ff @(posedge clk) begin
    if (rst) last_cmd <= 4'd0;
    else     last_cmd <= cmd;
  end

  assign bank_open = open_v;

  // R13: reset leaves no flag and no open bank
  p_reset_state_r13: assert property (@(posedge clk)
    rst |=> (!viol_flag && (bank_open == 4'd0)));
endmodule

// File: tb/sim_ddr_cmd_monitor.sv
module sim_ddr_cmd_monitor;
  localparam int K_NOP = 0, K_MRS = 1, K_EMRS = 2, K_AREF = 3, K_SREF = 4,
                 K_ACT = 5, K_RD = 6, K_WR = 7, K_BST = 8, K_PRE = 9, K_PREA = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_flag = 1'b0, cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0, bl_sel = 2'b10;
  logic a10 = 1'b0;
  logic [3:0] last_cmd, bank_open, viol_code;
  logic viol_flag;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] q_open[$], q_code[$], q_cmd[$];
  string q_tag[$];

  always #5 clk = ~clk;

  ddr_cmd_monitor u0 (
    .clk(clk), .rst(rst), .clr_flag(clr_flag), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .bl_sel(bl_sel), .last_cmd(last_cmd), .bank_open(bank_open),
    .viol_flag(viol_flag), .viol_code(viol_code)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares outputs after each edge against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_open.size() > 0) begin
        logic [3:0] eo, ec, em;
        string t;
        eo = q_open.pop_front();
        ec = q_code.pop_front();
        em = q_cmd.pop_front();
        t  = q_tag.pop_front();
        check(bank_open == eo, {t, " bank_open"}, bank_open, eo);
        check(viol_code == ec, {t, " viol_code"}, viol_code, ec);
        check(viol_flag == (ec != 0), {t, " viol_flag"}, viol_flag, ec != 0);
        check(last_cmd == em, {t, " last_cmd"}, last_cmd, em);
      end
    end
  end

  task automatic cyc(input int k, input logic [1:0] b, input logic ap,
                     input logic [3:0] eo, input logic [3:0] ec, input string tag,
                     input logic ck = 1'b1, input logic clr = 1'b0, input int ecmd = -1);
    @(negedge clk);
    cke = ck; clr_flag = clr; ba = b; a10 = ap; cs_n = 1'b0;
    case (k)
      K_MRS:   begin {ras_n, cas_n, we_n} = 3'b000; ba = 2'b00; end
      K_EMRS:  begin {ras_n, cas_n, we_n} = 3'b000; ba = 2'b01; end
      K_AREF:  {ras_n, cas_n, we_n} = 3'b001;
      K_SREF:  {ras_n, cas_n, we_n} = 3'b001;
      K_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      K_RD:    {ras_n, cas_n, we_n} = 3'b101;
      K_WR:    {ras_n, cas_n, we_n} = 3'b100;
      K_BST:   {ras_n, cas_n, we_n} = 3'b110;
      K_PRE:   begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b0; end
      K_PREA:  begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b1; end
      default: begin {ras_n, cas_n, we_n} = 3'b111; cs_n = 1'b1; end
    endcase
    q_open.push_back(eo);
    q_code.push_back(ec);
    q_cmd.push_back((ecmd < 0) ? 4'(k) : 4'(ecmd));
    q_tag.push_back(tag);
  endtask

  task automatic nops(input int n, input logic [3:0] eo, input logic [3:0] ec, input string tag);
    for (int i = 0; i < n; i++) cyc(K_NOP, 2'd0, 1'b0, eo, ec, tag);
  endtask

  task automatic do_reset(input logic [1:0] bl);
    @(negedge clk);
    rst = 1'b1; cke = 1'b1; clr_flag = 1'b0; cs_n = 1'b1;
    {ras_n, cas_n, we_n} = 3'b111; bl_sel = bl;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(viol_flag == 1'b0, "R13 reset flag", viol_flag, 0);
    check(viol_code == 4'd0, "R13 reset code", viol_code, 0);
    check(bank_open == 4'd0, "R13 reset banks", bank_open, 0);
    check(last_cmd == 4'd0, "R13 reset last_cmd", last_cmd, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // legal open / read / close / reopen at exact limits (R7 R8 R9)
    do_reset(2'b10);
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R2 activate bank A");
    nops(2, 4'b0001, 0, "R7 wait");
    cyc(K_RD, 2'd0, 0, 4'b0001, 0, "R7 read at tRCD");
    nops(2, 4'b0001, 0, "R8 wait");
    cyc(K_PRE, 2'd0, 0, 4'b0000, 0, "R8 precharge at tRAS");
    nops(2, 4'b0000, 0, "R9 wait");
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R9 activate at tRP and tRC");

    // R7 early read
    do_reset(2'b10);
    cyc(K_ACT, 2'd1, 0, 4'b0010, 0, "R2 activate bank B");
    cyc(K_NOP, 2'd0, 0, 4'b0010, 0, "R7 wait");
    cyc(K_RD, 2'd1, 0, 4'b0010, 6, "R7 read before tRCD");

    // R11 idle access, R13 sticky and clear
    do_reset(2'b10);
    cyc(K_RD, 2'd2, 0, 4'b0000, 4, "R11 read to idle bank");
    cyc(K_ACT, 2'd0, 0, 4'b0001, 4, "R13 code held");
    cyc(K_ACT, 2'd1, 0, 4'b0011, 4, "R13 first code kept over tRRD break");
    cyc(K_NOP, 2'd0, 0, 4'b0011, 0, "R13 clear", 1'b1, 1'b1);

    // R11 activate to open bank
    do_reset(2'b10);
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R11 open");
    nops(2, 4'b0001, 0, "R11 wait");
    cyc(K_ACT, 2'd0, 0, 4'b0001, 3, "R11 activate open bank");

    // R10 cross-bank activate spacing
    do_reset(2'b10);
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R10 first");
    cyc(K_ACT, 2'd1, 0, 4'b0011, 10, "R10 activate before tRRD");

    // R5 mode set with open bank
    do_reset(2'b10);
    cyc(K_ACT, 2'd3, 0, 4'b1000, 0, "R2 activate bank D");
    cyc(K_NOP, 2'd0, 0, 4'b1000, 0, "R5 wait");
    cyc(K_MRS, 2'd0, 0, 4'b1000, 2, "R5 mode set with bank open");

    // R6 mode recovery
    do_reset(2'b10);
    cyc(K_MRS, 2'd0, 0, 4'b0000, 0, "R1 mode set");
    cyc(K_NOP, 2'd0, 0, 4'b0000, 0, "R6 wait");
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R6 activate at tMRD");
    do_reset(2'b10);
    cyc(K_EMRS, 2'd0, 0, 4'b0000, 0, "R1 extended mode set");
    cyc(K_ACT, 2'd0, 0, 4'b0001, 1, "R6 activate before tMRD");

    // R8 early precharge
    do_reset(2'b10);
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R8 open");
    nops(3, 4'b0001, 0, "R8 wait");
    cyc(K_PRE, 2'd0, 0, 4'b0000, 7, "R8 precharge before tRAS");

    // R12 write with auto precharge blocks column commands
    do_reset(2'b10);
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R12 open A");
    cyc(K_NOP, 2'd0, 0, 4'b0001, 0, "R12 wait");
    cyc(K_ACT, 2'd1, 0, 4'b0011, 0, "R12 open B");
    cyc(K_WR, 2'd0, 1, 4'b0010, 0, "R4 write auto precharge closes A");
    cyc(K_RD, 2'd1, 0, 4'b0010, 5, "R12 read during auto-precharge write burst");

    // R4 reactivation after auto precharge, 4-beat burst
    do_reset(2'b10);
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R4 open");
    nops(2, 4'b0001, 0, "R4 wait");
    cyc(K_WR, 2'd0, 1, 4'b0000, 0, "R4 write auto precharge");
    nops(3, 4'b0000, 0, "R4 wait");
    cyc(K_ACT, 2'd0, 0, 4'b0001, 8, "R4 activate before burst+tRP");
    do_reset(2'b10);
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R4 open");
    nops(2, 4'b0001, 0, "R4 wait");
    cyc(K_WR, 2'd0, 1, 4'b0000, 0, "R4 write auto precharge");
    nops(5, 4'b0000, 0, "R4 wait");
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R4 activate after burst+tRP");

    // R12 8-beat burst stretches the same window
    do_reset(2'b11);
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R12 open");
    nops(2, 4'b0001, 0, "R12 wait");
    cyc(K_WR, 2'd0, 1, 4'b0000, 0, "R12 write auto precharge BL8");
    nops(5, 4'b0000, 0, "R12 wait");
    cyc(K_ACT, 2'd0, 0, 4'b0001, 8, "R12 BL8 activate one cycle too early");

    // R9 row cycle after read with auto precharge, 2-beat burst
    do_reset(2'b01);
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R9 open");
    nops(2, 4'b0001, 0, "R9 wait");
    cyc(K_RD, 2'd0, 1, 4'b0000, 0, "R4 read auto precharge");
    nops(3, 4'b0000, 0, "R9 wait");
    cyc(K_ACT, 2'd0, 0, 4'b0001, 9, "R9 activate before tRC");

    // R3 single versus all-bank precharge
    do_reset(2'b10);
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R3 open A");
    cyc(K_NOP, 2'd0, 0, 4'b0001, 0, "R3 wait");
    cyc(K_ACT, 2'd2, 0, 4'b0101, 0, "R3 open C");
    nops(3, 4'b0101, 0, "R3 wait");
    cyc(K_PRE, 2'd0, 0, 4'b0100, 0, "R3 single precharge closes A only");
    cyc(K_NOP, 2'd0, 0, 4'b0100, 0, "R3 wait");
    cyc(K_PREA, 2'd0, 1, 4'b0000, 0, "R3 all-bank precharge ignores ba");

    // R1 refresh and burst stop, R14 clock-enable handling
    do_reset(2'b10);
    cyc(K_AREF, 2'd0, 0, 4'b0000, 0, "R1 auto refresh idle");
    cyc(K_BST, 2'd0, 0, 4'b0000, 0, "R1 burst stop");
    cyc(K_SREF, 2'd0, 0, 4'b0000, 0, "R14 self refresh entry", 1'b0);
    cyc(K_ACT, 2'd0, 0, 4'b0000, 0, "R14 activate ignored", 1'b0, 1'b0, 11);
    cyc(K_NOP, 2'd0, 0, 4'b0000, 0, "R14 exit cycle ignored", 1'b1, 1'b0, 11);
    cyc(K_ACT, 2'd0, 0, 4'b0001, 0, "R14 decoding resumes");

    @(negedge clk);
    cs_n = 1'b1;
    {ras_n, cas_n, we_n} = 3'b111;
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule